// File: doc/BRIEF.md
# Processor Status Word Register File

This block keeps the processor's combined 32-bit status word. The word has three views. The flag view holds the arithmetic flags N, Z, C and V and the sticky saturation flag Q. The exception view holds the number of the exception now being serviced. The execution view holds the instruction-state bit and the resume index of a multi-register transfer that was interrupted. The ALU drives flag-update strobes and results into the block. The exception controller supplies the active exception number. The load/store sequencer reports when a transfer is suspended or resumed.

Move-from-status instructions read one view, or the whole word, through a masked combinational port. Move-to-status instructions write through a port that only the flag bits obey. On exception entry the block captures a registered snapshot of the full word, which the stacking logic saves. On exception return the saved word is loaded back through a restore port.

A two-state machine governs the resume index. In `RS_IDLE` no transfer is parked and bits [15:12] read zero. The *suspend* transition (`RS_IDLE` to `RS_HELD`) captures the next register number. In `RS_HELD` the index is frozen. The *resume* transition (`RS_HELD` to `RS_IDLE`) clears it. The *restore* transition, taken from either state, enters `RS_HELD` when the restored index is nonzero and `RS_IDLE` otherwise.

Top module: `psr_file`

## Requirements
- R1: After reset every bit of the status word reads zero in all four views, the snapshot reads zero and `mt_parked` is 0.
- R2: With `alu_nz_we` high, N (bit 31) takes `alu_result[31]` and Z (bit 30) is set exactly when `alu_result` is zero. Without the strobe, both flags hold.
- R3: C (bit 29) loads `alu_carry` when `alu_c_we` is high. V (bit 28) loads `alu_ovf` when `alu_v_we` is high. Each flag holds when its own strobe is low.
- R4: Q (bit 27) is set by `alu_sat` and stays set through any ALU flag update. It is cleared only by a flag-view status write with bit 27 zero, or by a restore.
- R5: A status write (`msr_we`) with `msr_sel` 0 (flags) or 3 (all) copies `msr_data[31:27]` into bits [31:27]. With `msr_sel` 1 or 2 the write changes nothing. No status write ever changes the exception number, the T bit or the resume index.
- R6: `rd_data` is the word masked by `rd_sel`: 0 gives the word AND 0xF8000000, 1 gives the word AND 0x000001FF, 2 gives the word AND 0x0100F000, and 3 gives the full word. All other bits read zero.
- R7: `exc_we` loads `exc_num` into bits [8:0]. Examples of stored values are 0 for thread level, 2 for NMI, 11 for supervisor call and 16+n for external interrupt n.
- R8: In `RS_IDLE`, `mt_suspend` captures `mt_next_reg` into bits [15:12] and enters `RS_HELD` (`mt_parked`=1). In `RS_HELD`, `mt_suspend` is ignored, and `mt_resume` clears [15:12] and returns to `RS_IDLE`. In `RS_IDLE`, `mt_resume` has no effect.
- R9: `tstate_we` loads `tstate_val` into the T bit (bit 24). Otherwise the T bit holds.
- R10: `entry_snap` copies the word as it stood before that clock edge into `snap_word`, which then holds until the next `entry_snap`.
- R11: `ret_we` loads `ret_word` AND 0xF900F1FF into the word. It overrides every other update in the same cycle and sets `mt_parked` to whether `ret_word[15:12]` is nonzero.
- R12: In the same cycle, an ALU strobe wins over a status write for N, Z, C and V, and `alu_sat` leaves Q set even when a status write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_nz_we | input | 1 | Update N and Z from the result |
| alu_result | input | 32 | ALU result word |
| alu_c_we | input | 1 | Update C |
| alu_carry | input | 1 | Carry/borrow from ALU |
| alu_v_we | input | 1 | Update V |
| alu_ovf | input | 1 | Signed overflow from ALU |
| alu_sat | input | 1 | Saturating operation clipped |
| exc_we | input | 1 | Load exception number |
| exc_num | input | 9 | Active exception number |
| mt_suspend | input | 1 | Multi-register transfer interrupted |
| mt_next_reg | input | 4 | Next register still to transfer |
| mt_resume | input | 1 | Parked transfer resumed |
| tstate_we | input | 1 | Load instruction-state bit |
| tstate_val | input | 1 | Instruction-state value |
| msr_we | input | 1 | Status write strobe |
| msr_sel | input | 2 | Status write view select |
| msr_data | input | 32 | Status write data |
| rd_sel | input | 2 | Read view select |
| rd_data | output | 32 | Masked read view |
| entry_snap | input | 1 | Capture snapshot for stacking |
| snap_word | output | 32 | Captured full word |
| ret_we | input | 1 | Restore word on return |
| ret_word | input | 32 | Word to restore |
| mt_parked | output | 1 | Resume state is `RS_HELD` |

## Verification
If the resume state machine is wrong, it shows on the first read of the execution view after a suspend, a second suspend or a resume. It also shows on `mt_parked` one cycle after the event. A flag register that drops a sticky Q or accepts a write it should ignore shows in the flag view on the very next cycle. Each of these events is therefore followed by an immediate read of all four views. A bad snapshot or a restore that lets through a lower-priority update appears on `snap_word` or `rd_data` one edge after `entry_snap` or `ret_we`. The sweeps cover every 5-bit flag pattern under every write select, every exception number up to 255 and every resume index.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_W    = 32;
    localparam int NFLAGS   = 5;
    localparam int N_POS    = 31;
    localparam int Q_POS    = 27;
    localparam int T_POS    = 24;
    localparam int RIDX_LSB = 12;
    localparam int RIDX_W   = 4;
    localparam int EXC_W    = 9;

    // flag vector index order, matches bits [31:27]
    localparam int F_N = 4;
    localparam int F_Z = 3;
    localparam int F_C = 2;
    localparam int F_V = 1;
    localparam int F_Q = 0;

    localparam logic [PSR_W-1:0] FLAG_MASK = {{NFLAGS{1'b1}}, {Q_POS{1'b0}}};
    localparam logic [PSR_W-1:0] EXC_MASK  = {{(PSR_W-EXC_W){1'b0}}, {EXC_W{1'b1}}};
    localparam logic [PSR_W-1:0] EXEC_MASK = (PSR_W'(1) << T_POS)
                                           | (PSR_W'((1 << RIDX_W) - 1) << RIDX_LSB);
    localparam logic [PSR_W-1:0] KEEP_MASK = FLAG_MASK | EXC_MASK | EXEC_MASK;

    typedef enum logic [1:0] {
        VIEW_FLAGS = 2'd0,
        VIEW_EXC   = 2'd1,
        VIEW_EXEC  = 2'd2,
        VIEW_ALL   = 2'd3
    } view_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HELD = 1'b1
    } rs_state_e;
endpackage

// File: rtl/psr_flags.sv
module psr_flags
    import psr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nz_we,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              c_we,
    input  logic              c_in,
    input  logic              v_we,
    input  logic              v_in,
    input  logic              sat_hit,
    input  logic              msr_we,
    input  logic [NFLAGS-1:0] msr_flags,
    input  logic              rest_we,
    input  logic [NFLAGS-1:0] rest_flags,
    output logic [NFLAGS-1:0] flags_q
);
    logic [NFLAGS-1:0] flags_d;

    // priority: restore > sat set on Q > ALU strobes > status write
    always_comb begin
        flags_d = flags_q;
        if (msr_we) flags_d = msr_flags;
        if (nz_we) begin
            flags_d[F_N] = alu_res[DATA_W-1];
            flags_d[F_Z] = (alu_res == '0);
        end
        if (c_we)    flags_d[F_C] = c_in;
        if (v_we)    flags_d[F_V] = v_in;
        if (sat_hit) flags_d[F_Q] = 1'b1;
        if (rest_we) flags_d = rest_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assert_q_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[F_Q] && !msr_we && !rest_we) |=> flags_q[F_Q]);

    assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_we && !rest_we) |=> (flags_q[F_Z] == ($past(alu_res) == '0)));

    assert_alu_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && msr_we && !rest_we) |=> (flags_q[F_C] == $past(c_in)));
endmodule

// File: rtl/psr_exec.sv
module psr_exec
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mt_suspend,
    input  logic [RIDX_W-1:0] mt_next,
    input  logic              mt_resume,
    input  logic              t_we,
    input  logic              t_in,
    input  logic              rest_we,
    input  logic [RIDX_W-1:0] rest_ridx,
    input  logic              rest_t,
    output logic [RIDX_W-1:0] ridx_q,
    output logic              t_q,
    output logic              parked
);
    rs_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (mt_suspend) state_d = RS_HELD;
            RS_HELD: if (mt_resume)  state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
        if (rest_we) state_d = (rest_ridx != '0) ? RS_HELD : RS_IDLE;
    end

    // outputs: resume index and instruction-state bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ridx_q <= '0;
            t_q    <= 1'b0;
        end else begin
            if (rest_we) begin
                ridx_q <= rest_ridx;
            end else begin
                unique case (state_q)
                    RS_IDLE: if (mt_suspend) ridx_q <= mt_next;
                    RS_HELD: if (mt_resume)  ridx_q <= '0;
                    default: ridx_q <= '0;
                endcase
            end
            if (rest_we)   t_q <= rest_t;
            else if (t_we) t_q <= t_in;
        end
    end

    assign parked = (state_q == RS_HELD);

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE && mt_suspend && !rest_we)
        |=> (state_q == RS_HELD && ridx_q == $past(mt_next)));

    assert_held_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HELD && !mt_resume && !rest_we) |=> $stable(ridx_q));

    assert_restore_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rest_we |=> (parked == ($past(rest_ridx) != '0)));
endmodule

// File: rtl/psr_view.sv
module psr_view
    import psr_pkg::*;
(
    input  logic [PSR_W-1:0] word,
    input  logic [1:0]       sel,
    output logic [PSR_W-1:0] view
);
    always_comb begin
        unique case (view_e'(sel))
            VIEW_FLAGS: view = word & FLAG_MASK;
            VIEW_EXC:   view = word & EXC_MASK;
            VIEW_EXEC:  view = word & EXEC_MASK;
            VIEW_ALL:   view = word;
            default:    view = word;
        endcase
    end
endmodule

// File: rtl/psr_file.sv
module psr_file
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_nz_we,
    input  logic [PSR_W-1:0]  alu_result,
    input  logic              alu_c_we,
    input  logic              alu_carry,
    input  logic              alu_v_we,
    input  logic              alu_ovf,
    input  logic              alu_sat,
    input  logic              exc_we,
    input  logic [EXC_W-1:0]  exc_num,
    input  logic              mt_suspend,
    input  logic [RIDX_W-1:0] mt_next_reg,
    input  logic              mt_resume,
    input  logic              tstate_we,
    input  logic              tstate_val,
    input  logic              msr_we,
    input  logic [1:0]        msr_sel,
    input  logic [PSR_W-1:0]  msr_data,
    input  logic [1:0]        rd_sel,
    output logic [PSR_W-1:0]  rd_data,
    input  logic              entry_snap,
    output logic [PSR_W-1:0]  snap_word,
    input  logic              ret_we,
    input  logic [PSR_W-1:0]  ret_word,
    output logic              mt_parked
);
    logic [NFLAGS-1:0] flags_q;
    logic [RIDX_W-1:0] ridx_q;
    logic              t_q;
    logic [EXC_W-1:0]  exc_q;
    logic [PSR_W-1:0]  snap_q;
    logic [PSR_W-1:0]  word;
    logic              msr_flag_we;
    logic              unused_bits;

    assign msr_flag_we = msr_we && (view_e'(msr_sel) == VIEW_FLAGS
                                 || view_e'(msr_sel) == VIEW_ALL);
    assign unused_bits = ^(msr_data & ~FLAG_MASK) ^ ^(ret_word & ~KEEP_MASK);

    psr_flags #(.DATA_W(PSR_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .nz_we      (alu_nz_we),
        .alu_res    (alu_result),
        .c_we       (alu_c_we),
        .c_in       (alu_carry),
        .v_we       (alu_v_we),
        .v_in       (alu_ovf),
        .sat_hit    (alu_sat),
        .msr_we     (msr_flag_we),
        .msr_flags  (msr_data[N_POS:Q_POS]),
        .rest_we    (ret_we),
        .rest_flags (ret_word[N_POS:Q_POS]),
        .flags_q    (flags_q)
    );

    psr_exec u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .mt_suspend (mt_suspend),
        .mt_next    (mt_next_reg),
        .mt_resume  (mt_resume),
        .t_we       (tstate_we),
        .t_in       (tstate_val),
        .rest_we    (ret_we),
        .rest_ridx  (ret_word[RIDX_LSB +: RIDX_W]),
        .rest_t     (ret_word[T_POS]),
        .ridx_q     (ridx_q),
        .t_q        (t_q),
        .parked     (mt_parked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_q  <= '0;
            snap_q <= '0;
        end else begin
            if (entry_snap) snap_q <= word;
            if (ret_we)      exc_q <= ret_word[EXC_W-1:0];
            else if (exc_we) exc_q <= exc_num;
        end
    end

    always_comb begin
        word                       = '0;
        word[N_POS:Q_POS]          = flags_q;
        word[T_POS]                = t_q;
        word[RIDX_LSB +: RIDX_W]   = ridx_q;
        word[EXC_W-1:0]            = exc_q;
    end

    psr_view u_view (
        .word (word),
        .sel  (rd_sel),
        .view (rd_data)
    );

    assign snap_word = snap_q;

    assert_view_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (view_e'(rd_sel) == VIEW_EXC) |-> ((rd_data & ~EXC_MASK) == '0));

    assert_exc_ignores_msr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_we && !exc_we && !ret_we) |=> $stable(exc_q));

    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_snap |=> $stable(snap_word));
endmodule

// File: tb/tb_psr_file.sv
module tb_psr_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_nz_we = 0, alu_c_we = 0, alu_carry = 0, alu_v_we = 0, alu_ovf = 0, alu_sat = 0;
    logic [31:0] alu_result = '0;
    logic        exc_we = 0;
    logic [8:0]  exc_num = '0;
    logic        mt_suspend = 0, mt_resume = 0;
    logic [3:0]  mt_next_reg = '0;
    logic        tstate_we = 0, tstate_val = 0;
    logic        msr_we = 0;
    logic [1:0]  msr_sel = '0;
    logic [31:0] msr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        entry_snap = 0;
    logic [31:0] snap_word;
    logic        ret_we = 0;
    logic [31:0] ret_word = '0;
    logic        mt_parked;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_w = '0;
    logic        exp_park = 1'b0;

    always #5 clk = ~clk;

    psr_file dut (
        .clk(clk), .rst_n(rst_n),
        .alu_nz_we(alu_nz_we), .alu_result(alu_result),
        .alu_c_we(alu_c_we), .alu_carry(alu_carry),
        .alu_v_we(alu_v_we), .alu_ovf(alu_ovf), .alu_sat(alu_sat),
        .exc_we(exc_we), .exc_num(exc_num),
        .mt_suspend(mt_suspend), .mt_next_reg(mt_next_reg), .mt_resume(mt_resume),
        .tstate_we(tstate_we), .tstate_val(tstate_val),
        .msr_we(msr_we), .msr_sel(msr_sel), .msr_data(msr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .entry_snap(entry_snap), .snap_word(snap_word),
        .ret_we(ret_we), .ret_word(ret_word),
        .mt_parked(mt_parked)
    );

    function automatic logic [31:0] viewof(int s, logic [31:0] w);
        case (s)
            0:       return w & 32'hF800_0000;
            1:       return w & 32'h0000_01FF;
            2:       return w & 32'h0100_F000;
            default: return w;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        alu_nz_we = 0; alu_c_we = 0; alu_v_we = 0; alu_sat = 0;
        exc_we = 0; mt_suspend = 0; mt_resume = 0; tstate_we = 0;
        msr_we = 0; entry_snap = 0; ret_we = 0;
    endtask

    task automatic view_all(string tag);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.5;
            chk(tag, rd_data, viewof(s, exp_w));
        end
        chk(tag, {31'd0, mt_parked}, {31'd0, exp_park});
    endtask

    task automatic view_one(string tag, int s);
        rd_sel = 2'(s);
        #0.5;
        chk(tag, rd_data, viewof(s, exp_w));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] wpat;
        logic [31:0] w0;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        view_all("R1");
        chk("R1 snap", snap_word, 32'h0);
        rst_n = 1'b1;
        step();

        // R2 N/Z from result
        for (int i = 0; i < 38; i++) begin
            if (i < 32)       wpat = 32'h1 << i;
            else if (i == 32) wpat = 32'h0;
            else if (i == 33) wpat = 32'hFFFF_FFFF;
            else if (i == 34) wpat = 32'h7FFF_FFFF;
            else if (i == 35) wpat = 32'h0;
            else if (i == 36) wpat = 32'h8000_0001;
            else              wpat = 32'h0001_0000;
            alu_nz_we = 1; alu_result = wpat;
            step(); quiet();
            exp_w[31] = wpat[31];
            exp_w[30] = (wpat == 0);
            view_one("R2", 0);
        end
        alu_result = 32'h0;
        step();
        view_one("R2 hold", 0);

        // R3 C and V
        for (int k = 0; k < 4; k++) begin
            alu_c_we = 1; alu_v_we = 1; alu_carry = k[0]; alu_ovf = k[1];
            step(); quiet();
            exp_w[29] = k[0]; exp_w[28] = k[1];
            view_one("R3", 0);
            alu_carry = ~k[0]; alu_ovf = ~k[1];
            step();
            view_one("R3 hold", 0);
        end
        alu_c_we = 1; alu_carry = 1; alu_ovf = 0;
        step(); quiet();
        exp_w[29] = 1;
        view_one("R3 c only", 0);

        // R4 sticky Q
        alu_sat = 1;
        step(); quiet();
        exp_w[27] = 1;
        view_one("R4 set", 0);
        alu_nz_we = 1; alu_c_we = 1; alu_v_we = 1; alu_result = 32'h0; alu_carry = 0; alu_ovf = 0;
        step(); quiet();
        exp_w[31:28] = 4'b0100;
        view_one("R4 keep", 0);
        msr_we = 1; msr_sel = 2'd1; msr_data = 32'h0;
        step(); quiet();
        view_one("R4 other view write", 0);
        msr_we = 1; msr_sel = 2'd0; msr_data = 32'h0;
        step(); quiet();
        exp_w[31:27] = 5'b0;
        view_one("R4 clear", 0);

        // setup other fields
        exc_we = 1; exc_num = 9'd11; tstate_we = 1; tstate_val = 1;
        mt_suspend = 1; mt_next_reg = 4'd5;
        step(); quiet();
        exp_w[8:0] = 9'd11; exp_w[24] = 1; exp_w[15:12] = 4'd5; exp_park = 1;
        view_all("R7 R8 R9 setup");

        // R5 R6 sweep of write selects and flag patterns
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 32; p++) begin
                msr_we = 1; msr_sel = 2'(s); msr_data = {5'(p), 27'h7FF_FFFF};
                step(); quiet();
                if (s == 0 || s == 3) exp_w[31:27] = 5'(p);
                view_all("R5 R6");
            end
        end

        // R7 exception numbers
        for (int n = 0; n < 256; n++) begin
            exc_we = 1; exc_num = 9'(n);
            step(); quiet();
            exp_w[8:0] = 9'(n);
            view_one("R7", 1);
        end
        exc_we = 1; exc_num = 9'd2;
        step(); quiet();
        exp_w[8:0] = 9'd2;
        view_all("R7 nmi");

        // R8 resume state machine
        mt_resume = 1;
        step(); quiet();
        exp_w[15:12] = 0; exp_park = 0;
        view_all("R8 resume");
        mt_resume = 1;
        step(); quiet();
        view_all("R8 idle resume");
        for (int r = 0; r < 16; r++) begin
            mt_suspend = 1; mt_next_reg = 4'(r);
            step(); quiet();
            exp_w[15:12] = 4'(r); exp_park = 1;
            view_all("R8 suspend");
            mt_suspend = 1; mt_next_reg = 4'(r) ^ 4'hF;
            step(); quiet();
            view_all("R8 second suspend");
            mt_resume = 1;
            step(); quiet();
            exp_w[15:12] = 0; exp_park = 0;
            view_all("R8 resume");
        end

        // R9 T bit
        tstate_we = 1; tstate_val = 0;
        step(); quiet();
        exp_w[24] = 0;
        view_one("R9 clear", 2);
        tstate_we = 1; tstate_val = 1;
        step(); quiet();
        exp_w[24] = 1;
        view_one("R9 set", 2);
        tstate_val = 0;
        step();
        view_one("R9 hold", 2);

        // R10 snapshot
        w0 = exp_w;
        entry_snap = 1; alu_nz_we = 1; alu_result = 32'h0;
        step(); quiet();
        exp_w[31:30] = 2'b01;
        chk("R10 snap", snap_word, w0);
        view_all("R10 word");
        alu_nz_we = 1; alu_result = 32'h8000_0000;
        step(); quiet();
        exp_w[31:30] = 2'b10;
        chk("R10 snap hold", snap_word, w0);

        // R11 restore
        ret_we = 1; ret_word = 32'hFFFF_FFFF;
        alu_nz_we = 1; alu_result = 32'h0; msr_we = 1; msr_sel = 2'd0; msr_data = 32'h0;
        exc_we = 1; exc_num = 9'd3; mt_suspend = 1; mt_next_reg = 4'd2;
        tstate_we = 1; tstate_val = 0;
        step(); quiet();
        exp_w = 32'hF900_F1FF; exp_park = 1;
        view_all("R11 all ones");
        ret_we = 1; ret_word = 32'h1234_5678;
        step(); quiet();
        exp_w = 32'h1234_5678 & 32'hF900_F1FF; exp_park = 1;
        view_all("R11 pattern");
        ret_we = 1; ret_word = 32'h8000_0003;
        mt_resume = 1;
        step(); quiet();
        exp_w = 32'h8000_0003; exp_park = 0;
        view_all("R11 no index");

        // R12 same-cycle priority
        msr_we = 1; msr_sel = 2'd3; msr_data = 32'h0;
        alu_nz_we = 1; alu_result = 32'h8000_0000; alu_sat = 1;
        step(); quiet();
        exp_w[31:27] = 5'b10001;
        view_one("R12 nz and q", 0);
        msr_we = 1; msr_sel = 2'd0; msr_data = 32'hFFFF_FFFF;
        alu_c_we = 1; alu_carry = 0; alu_v_we = 1; alu_ovf = 0;
        step(); quiet();
        exp_w[31:27] = 5'b11001;
        view_one("R12 c v", 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule